// File: doc/BRIEF.md
# Raw Disk Bit-Cell Capture Counter

This block watches the read-pulse line of a floppy read head and turns it into a stream of bit cells. Every cell is one bit time of the recorded track. A cell holds a 1 when a flux-transition pulse arrived inside it and a 0 otherwise. Each cell is shifted into a raw-bit register that the host can poll several times per nibble. A small counter tells the host how many bits are new since its last poll, so the host can rebuild the exact bit sequence. This sequence includes the extra 0 bits that follow the eight 1s of a self-sync byte, which a nibble shifter that frames on a set top bit would hide.

A second counter measures the current run of 0 cells. When a 1 cell ends a run, the run's length is kept in a readable register. A flag rises once the run reaches a threshold set by the host. Long runs of missing transitions are where a normal controller starts returning random 1 bits, so this flag marks such regions for protection checks and for duplication checks. The number of sample clocks per cell is a parameter. The default of 8 suits a 2 MHz sample clock with a 4 µs cell, and a value of 4 suits a 1 MHz sample clock.

Top module: `rawbit_capture_top`

## Requirements
- R1: While reset is held and right after it, raw_bits, unread, overrun, zero_run and last_run are 0, and long_run is 0 for any nonzero threshold.
- R2: A cell lasts SPC sample clocks (SPC is 8 by default). Counting starts at the first clock after reset is released. A cell is 1 when a rising edge of rd_pulse, after a two-flop synchronizer, falls inside it, and 0 otherwise.
- R3: At the end of each cell, its bit enters raw_bits at bit 0 and every older bit moves up one place toward bit 7.
- R4: unread counts the cells completed since the last host_rd and stops at 8. A one-cycle host_rd sets it to 0. If host_rd is high in the same cycle that a cell completes, unread becomes 1.
- R5: If a cell completes while unread is already 8 and host_rd is low, overrun becomes 1. It stays 1 until a host_rd cycle clears it.
- R6: zero_run rises by one for each 0 cell and holds at 255.
- R7: A 1 cell copies the value zero_run had before the cell into last_run and sets zero_run to 0. After eight 1 cells, k 0 cells and a 1 cell, last_run therefore equals k.
- R8: long_run is 1 exactly while zero_run is greater than or equal to the zthresh input. The host normally programs zthresh to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (2 MHz by default) |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_pulse | input | 1 | Read-head flux pulse, asynchronous |
| host_rd | input | 1 | One-cycle host poll strobe; clears unread and overrun |
| zthresh | input | 8 | Long zero-run threshold |
| raw_bits | output | 8 | Last eight cells, newest at bit 0 |
| unread | output | 4 | Cells since last poll, 0 to 8 |
| overrun | output | 1 | Sticky: a cell was lost to an unpolled register |
| zero_run | output | 8 | Current run of 0 cells, saturating |
| last_run | output | 8 | Length of the zero run ended by the last 1 cell |
| long_run | output | 1 | zero_run has reached zthresh |

## Verification
Two conditions are the hardest to reach from the ports. One is zero_run saturating, which needs more than 255 empty cells in a row. The other is a host poll that lands in the same sample clock as a cell boundary. The stimulus drives one dedicated stretch of 300 pulse-free cells while it moves zthresh. It also places some host_rd strobes on the last sample clock of a cell on purpose, so the clear and the new count collide. Self-sync patterns with two and with three trailing zeros are driven as directed cases. Seeded random cells with random polls then let overrun build up and clear.

// File: rtl/rbc_pkg.sv
`timescale 1ns/1ps
// Package rbc_pkg: shared sizing constants for the raw bit-cell capture block.
// Assumes one sample clock domain; the read pulse is the only async input.
package rbc_pkg;
    localparam int SPC_2MHZ    = 8;  // samples per 4 us cell at 2 MHz
    localparam int SPC_1MHZ    = 4;  // samples per 4 us cell at 1 MHz
    localparam int RAW_W_DEF   = 8;  // raw shift register width
    localparam int RUN_W_DEF   = 8;  // zero-run counter width
endpackage

// File: rtl/rbc_sampler.sv
`timescale 1ns/1ps
// Module rbc_sampler: synchronizes the read pulse, detects its rising edge
// and groups sample clocks into bit cells of SPC samples each.
// Assumes SPC >= 2 and that a pulse stays high at least one sample clock.
module rbc_sampler #(
    parameter int SPC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_pulse,
    output logic cell_stb,
    output logic cell_bit
);
    localparam int TW = (SPC > 2) ? $clog2(SPC) : 1;
    localparam logic [TW-1:0] TLAST = TW'(SPC - 1);

    logic          sync1, sync2, prev;
    logic [TW-1:0] tmr;
    logic          seen;
    logic          edge_now;

    // Rising edge of the synchronized pulse.
    assign edge_now = sync2 & ~prev;
    // Cell ends on the last sample of the window.
    assign cell_stb = (tmr == TLAST);
    // Cell is a one if an edge arrived anywhere in the window.
    assign cell_bit = seen | edge_now;

    // Two-flop synchronizer and edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= rd_pulse;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // Cell timer and per-cell edge memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr  <= '0;
            seen <= 1'b0;
        end else begin
            tmr  <= cell_stb ? '0 : tmr + 1'b1;
            seen <= cell_stb ? 1'b0 : (seen | edge_now);
        end
    end

    // R2: cell boundaries never fall on adjacent sample clocks.
    assert_cell_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cell_stb |=> !cell_stb);
    // R2: an edge seen mid-cell is remembered into the next sample.
    assert_edge_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && !cell_stb) |=> cell_bit);
endmodule

// File: rtl/rbc_shifter.sv
`timescale 1ns/1ps
// Module rbc_shifter: raw-bit shift register, unread-bit counter and sticky
// overrun flag. Assumes cell_stb is a single-cycle strobe per cell.
module rbc_shifter #(
    parameter int RAW_W = 8,
    parameter int CW    = $clog2(RAW_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_stb,
    input  logic             cell_bit,
    input  logic             host_rd,
    output logic [RAW_W-1:0] raw,
    output logic [CW-1:0]    cnt,
    output logic             ovf
);
    localparam logic [CW-1:0] CFULL = CW'(RAW_W);

    // Shift each completed cell in at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        raw <= '0;
        else if (cell_stb) raw <= {raw[RAW_W-2:0], cell_bit};
    end

    // Count unread cells; a poll restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (host_rd)                    cnt <= cell_stb ? CW'(1) : '0;
        else if (cell_stb && cnt != CFULL)   cnt <= cnt + 1'b1;
    end

    // Sticky overrun when a cell lands on a full, unpolled register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovf <= 1'b0;
        else if (host_rd)                    ovf <= 1'b0;
        else if (cell_stb && cnt == CFULL)   ovf <= 1'b1;
    end

    // R3: the new bit appears at bit 0, older bits move up.
    assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cell_stb |=> (raw[0] == $past(cell_bit)) &&
                     (raw[RAW_W-1:1] == $past(raw[RAW_W-2:0])));
    // R4: the unread count never passes the register width.
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CFULL);
    // R5: overrun only rises from a cell arriving on a full register.
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(cnt) == CFULL) && $past(cell_stb) && !$past(host_rd));
endmodule

// File: rtl/rbc_runlen.sv
`timescale 1ns/1ps
// Module rbc_runlen: measures runs of 0 cells, latches the finished run
// length on each 1 cell and flags runs at or above a host threshold.
module rbc_runlen #(
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_stb,
    input  logic             cell_bit,
    input  logic [RUN_W-1:0] thresh,
    output logic [RUN_W-1:0] zr,
    output logic [RUN_W-1:0] lr,
    output logic             long_flag
);
    localparam logic [RUN_W-1:0] ZMAX = '1;

    // Flag compares the live run against the threshold.
    assign long_flag = (zr >= thresh);

    // Zero-run counter with saturation and run-length latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zr <= '0;
            lr <= '0;
        end else if (cell_stb) begin
            if (cell_bit) begin
                lr <= zr;
                zr <= '0;
            end else if (zr != ZMAX) begin
                zr <= zr + 1'b1;
            end
        end
    end

    // R7: a one cell latches the finished run and restarts the count.
    assert_run_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_stb && cell_bit) |=> (zr == '0) && (lr == $past(zr)));
    // R6: a saturated run stays saturated on further zero cells.
    assert_run_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_stb && !cell_bit && zr == ZMAX) |=> zr == ZMAX);
    // R6: without a cell the run counter holds.
    assert_run_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_stb |=> $stable(zr));
endmodule

// File: rtl/rawbit_capture_top.sv
`timescale 1ns/1ps
// Module rawbit_capture_top: raw bit-cell capture counter. Turns read pulses
// into cells, exposes them for frequent host polling and measures zero runs.
// Assumes clk is the sample clock and SPC sample clocks make one bit cell.
module rawbit_capture_top
    import rbc_pkg::*;
#(
    parameter int SPC   = SPC_2MHZ,
    parameter int RAW_W = RAW_W_DEF,
    parameter int RUN_W = RUN_W_DEF,
    parameter int CW    = $clog2(RAW_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_pulse,
    input  logic             host_rd,
    input  logic [RUN_W-1:0] zthresh,
    output logic [RAW_W-1:0] raw_bits,
    output logic [CW-1:0]    unread,
    output logic             overrun,
    output logic [RUN_W-1:0] zero_run,
    output logic [RUN_W-1:0] last_run,
    output logic             long_run
);
    logic cell_stb;
    logic cell_bit;

    rbc_sampler #(.SPC(SPC)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_pulse (rd_pulse),
        .cell_stb (cell_stb),
        .cell_bit (cell_bit)
    );

    rbc_shifter #(.RAW_W(RAW_W), .CW(CW)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cell_stb (cell_stb),
        .cell_bit (cell_bit),
        .host_rd  (host_rd),
        .raw      (raw_bits),
        .cnt      (unread),
        .ovf      (overrun)
    );

    rbc_runlen #(.RUN_W(RUN_W)) u_runlen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cell_stb  (cell_stb),
        .cell_bit  (cell_bit),
        .thresh    (zthresh),
        .zr        (zero_run),
        .lr        (last_run),
        .long_flag (long_run)
    );

    // R1: reset leaves every capture output cleared.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (raw_bits == '0) && (unread == '0) && !overrun &&
                   (zero_run == '0) && (last_run == '0));
endmodule

// File: tb/rawbit_capture_top_tb_top.sv
`timescale 1ns/1ps
// Bench: drives bit cells aligned to the default 8-sample cell timer and
// compares every output against a model built from the requirements.
module rawbit_capture_top_tb_top;
    localparam int SPC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_pulse = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] zthresh = 8'd8;
    logic [7:0] raw_bits;
    logic [3:0] unread;
    logic       overrun;
    logic [7:0] zero_run;
    logic [7:0] last_run;
    logic       long_run;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    logic [7:0] m_raw = '0;
    int         m_cnt = 0;
    bit         m_ovf = 0;
    int         m_zr = 0;
    int         m_lr = 0;

    always #2 clk = ~clk;

    rawbit_capture_top dut_i (
        .clk(clk), .rst_n(rst_n), .rd_pulse(rd_pulse), .host_rd(host_rd),
        .zthresh(zthresh), .raw_bits(raw_bits), .unread(unread),
        .overrun(overrun), .zero_run(zero_run), .last_run(last_run),
        .long_run(long_run)
    );

    function automatic bit exp_long(int zr, logic [7:0] th);
        return zr >= int'(th);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all();
        check("R3 raw_bits", int'(raw_bits), int'(m_raw));
        check("R4 unread", int'(unread), m_cnt);
        check("R5 overrun", int'(overrun), int'(m_ovf));
        check("R6 zero_run", int'(zero_run), m_zr);
        check("R7 last_run", int'(last_run), m_lr);
        check("R8 long_run", int'(long_run), int'(exp_long(m_zr, zthresh)));
    endtask

    // rdmode: 0 none, 1 poll mid-cell, 2 poll on the cell's last sample
    task automatic run_cell(input bit b, input int rdmode);
        for (int i = 0; i < SPC; i++) begin
            rd_pulse = b && (i == 2);
            host_rd  = (rdmode == 1 && i == 4) || (rdmode == 2 && i == SPC - 1);
            @(negedge clk);
        end
        rd_pulse = 1'b0;
        host_rd  = 1'b0;
        if (rdmode != 0) begin
            m_cnt = 0;
            m_ovf = 0;
        end
        if (m_cnt == 8) m_ovf = 1;
        else            m_cnt++;
        m_raw = {m_raw[6:0], b};
        if (b) begin
            m_lr = m_zr;
            m_zr = 0;
        end else if (m_zr < 255) begin
            m_zr++;
        end
        check_all();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check("R1 raw_bits", int'(raw_bits), 0);
        check("R1 unread", int'(unread), 0);
        check("R1 overrun", int'(overrun), 0);
        check("R1 zero_run", int'(zero_run), 0);
        check("R1 last_run", int'(last_run), 0);
        check("R1 long_run", int'(long_run), 0);
        rst_n = 1'b1;

        // R2/R3/R7: self-sync bytes with two trailing zeros
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < 8; k++) run_cell(1'b1, (k == 4) ? 1 : 0);
            run_cell(1'b0, 0);
            run_cell(1'b0, 0);
        end
        run_cell(1'b1, 1);
        check("R7 sync trailing zeros=2", int'(last_run), 2);

        // R7: non-standard sync with three trailing zeros
        for (int k = 0; k < 8; k++) run_cell(1'b1, 0);
        for (int k = 0; k < 3; k++) run_cell(1'b0, 0);
        run_cell(1'b1, 1);
        check("R7 sync trailing zeros=3", int'(last_run), 3);

        // R4/R5: let the register fill and overrun, then clear
        for (int k = 0; k < 12; k++) run_cell(k[0], 0);
        check("R5 overrun sticky", int'(overrun), 1);
        run_cell(1'b1, 2);
        check("R4 poll on cell edge", int'(unread), 1);

        // R6/R8: long missing-transition region with threshold moves
        zthresh = 8'd8;
        for (int k = 0; k < 300; k++) begin
            if (k == 100) zthresh = 8'd20;
            if (k == 200) zthresh = 8'd255;
            run_cell(1'b0, (k % 6 == 0) ? 1 : 0);
        end
        check("R6 saturated", int'(zero_run), 255);
        run_cell(1'b1, 1);
        check("R7 run after saturation", int'(last_run), 255);

        // random cells with random polls and thresholds
        for (int k = 0; k < 400; k++) begin
            if (k % 50 == 0) zthresh = 8'($urandom_range(0, 12));
            run_cell(1'($urandom_range(0, 2) != 0), int'($urandom_range(0, 5) < 3 ? 0 : $urandom_range(1, 2)));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule